// File: doc/BRIEF.md
# Line-Wide Instruction Fetch Cache

This block is a read-only, direct-mapped instruction cache. It sits between a fetch unit and the read half of an AXI memory port. The fetch unit offers a 32-bit byte address with a valid/ready handshake. One cycle after the handshake, the cache returns the whole line that contains that address. A line is exactly one AXI data beat wide.

When a fetch misses, the cache reserves a refill slot and issues a single-beat AXI read for the line-aligned address. The AXI ID of that read is the slot number. While the demand read is pending, the cache also reserves a slot for the following line, provided that line is neither cached nor already requested and a slot is free. Read data may come back in any order. Each beat is steered to its line by its ID. The fetch stays stalled until its own line is valid, and is then served from the array.

A flush handshake invalidates every line. The cache accepts a flush only when no read is outstanding. While a flush is requested, the cache starts no new refills, so the flush always completes.

Top module: `fetch_line_cache`

## Requirements
- R1: Out of reset, no line is valid, `ar_valid` is low and `flush_ready` is high. The first fetch to any address sees `fetch_ready` low.
- R2: In the cycle after a fetch handshake, `fetch_rdata` holds the line at the fetch address rounded down to `LINE_W/8` bytes. Bits `32*i+31 : 32*i` hold the 32-bit memory word at line base + 4*i.
- R3: A fetch whose line is cached sees `fetch_ready` high in the same cycle it is presented, and no AXI read is issued for it.
- R4: Every AXI read address has its low `log2(LINE_W/8)` bits equal to zero.
- R5: Under random `ar_ready` and `r_valid` back-pressure, every fetch is accepted within 100 cycles of being presented.
- R6: While `ar_valid` is high and `ar_ready` is low, `ar_valid`, `ar_id` and `ar_addr` stay unchanged.
- R7: Each issued read carries an ID below `SLOTS` that is not in use by another outstanding read. A data beat fills the line whose read carried the same ID, even when beats return in a different order from their reads.
- R8: A miss on line L also issues a read for line L+1 when L+1 is neither cached nor pending and a slot is free. A later fetch to L+1 then hits.
- R9: At most one read is outstanding per line address, and at most `SLOTS` reads are outstanding in total.
- R10: `flush_ready` is low whenever any read is outstanding. No read is issued in the cycle after an accepted flush.
- R11: After a flush handshake, every line is invalid. A fetch to a line that was cached before the flush misses and issues a new read.
- R12: `r_ready` is always high. The value of `r_resp` has no effect, so the beat's data fills the line whatever the response code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush_valid | input | 1 | Request to invalidate every line |
| flush_ready | output | 1 | Flush accepted (no read outstanding) |
| fetch_valid | input | 1 | Fetch request present |
| fetch_ready | output | 1 | Fetch accepted (line is cached) |
| fetch_addr | input | 32 | Fetch byte address |
| fetch_rdata | output | LINE_W | Full line, valid one cycle after handshake |
| ar_valid | output | 1 | AXI read address valid |
| ar_ready | input | 1 | AXI read address ready |
| ar_id | output | ID_W | AXI read ID (refill slot number) |
| ar_addr | output | 32 | Line-aligned AXI read address |
| r_valid | input | 1 | AXI read data valid |
| r_ready | output | 1 | AXI read data ready (tied high) |
| r_id | input | ID_W | ID of the returning beat |
| r_resp | input | 2 | Response code (not used) |
| r_data | input | LINE_W | One full line of read data |

## Verification
The bench builds the cache with 8 lines of 128 bits, two refill slots and a 3-bit ID. With only eight sets, random addresses spread over 24 lines evict each other often. With two slots, a single miss uses every slot through the demand read plus its next-line read. That makes it easy to reach the slot-full case, returning beats out of order, and flushes that must wait for both reads to drain. A small share of fetches falls in the top 64 bytes of the address space, so the next-line read wraps to line zero.

// File: rtl/flc_pkg.sv
// Shared constants and types for the line-wide fetch cache.
package flc_pkg;
    localparam int unsigned ADDR_W = 32;

    // Life cycle of one refill slot.
    typedef enum logic [1:0] {
        SLOT_FREE   = 2'd0,
        SLOT_QUEUED = 2'd1,
        SLOT_WAIT   = 2'd2
    } slot_state_e;
endpackage

// File: rtl/flc_tag_store.sv
// Tag and valid storage for a direct-mapped cache with two lookup ports.
// Assumes LINES is a power of two; clear takes priority over a write.
module flc_tag_store #(
    parameter int LINES = 16,
    parameter int TAG_W = 24,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [IDX_W-1:0] a_idx,
    input  logic [TAG_W-1:0] a_tag,
    output logic             a_hit,
    input  logic [IDX_W-1:0] b_idx,
    input  logic [TAG_W-1:0] b_tag,
    output logic             b_hit
);
    logic [LINES-1:0] vld_q;
    logic [TAG_W-1:0] tag_q [LINES];

    // Valid bits: cleared on reset and flush, set on fill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else if (clr) begin
            vld_q <= '0;
        end else if (wr_en) begin
            vld_q[wr_idx] <= 1'b1;
        end
    end

    // Tag array: written with the line tag on fill.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx] <= wr_tag;
        end
    end

    // Lookup ports: demand line and next line.
    always_comb begin
        a_hit = vld_q[a_idx] && (tag_q[a_idx] == a_tag);
        b_hit = vld_q[b_idx] && (tag_q[b_idx] == b_tag);
    end

    // R3
    fill_hits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !clr |=> vld_q[$past(wr_idx)] && (tag_q[$past(wr_idx)] == $past(wr_tag)));
endmodule

// File: rtl/flc_line_store.sv
// Line data array with one write port for fills and a registered read
// port for fetches; the read output only changes on a read enable.
module flc_line_store #(
    parameter int LINES  = 16,
    parameter int LINE_W = 128,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [LINE_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [LINE_W-1:0] rd_data
);
    logic [LINE_W-1:0] data_q [LINES];
    logic [LINE_W-1:0] rd_q;

    // Fill path: store a returned beat into its set.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            data_q[wr_idx] <= wr_data;
        end
    end

    // Fetch path: capture the addressed line on handshake (old data wins on a same-cycle write).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else if (rd_en) begin
            rd_q <= data_q[rd_idx];
        end
    end

    assign rd_data = rd_q;
endmodule

// File: rtl/flc_refill_tracker.sv
// Refill slot table. Each slot holds a line address and moves from free,
// to queued (waiting to be issued), to waiting (issued, data not back).
// The slot number is the AXI ID. Assumes SLOTS is a power of two, at
// least 2, and no wider than the ID field.
module flc_refill_tracker
    import flc_pkg::*;
#(
    parameter int SLOTS = 4,
    parameter int LA_W  = 28,
    parameter int OFF_W = 4,
    parameter int ID_W  = 4,
    localparam int SLOT_W = $clog2(SLOTS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_en,
    input  logic [LA_W-1:0]  alloc_line,
    output logic             free_any,
    output logic             any_busy,
    input  logic [LA_W-1:0]  qa_line,
    output logic             qa_pend,
    input  logic [LA_W-1:0]  qb_line,
    output logic             qb_pend,
    output logic             ar_valid,
    input  logic             ar_ready,
    output logic [ID_W-1:0]  ar_id,
    output logic [LA_W+OFF_W-1:0] ar_addr,
    input  logic             r_valid,
    input  logic [ID_W-1:0]  r_id,
    output logic             fill_en,
    output logic [LA_W-1:0]  fill_line
);
    slot_state_e       st_q   [SLOTS];
    logic [LA_W-1:0]   line_q [SLOTS];
    logic              ar_busy_q;
    logic [SLOT_W-1:0] ar_slot_q;
    logic [SLOT_W-1:0] free_idx;
    logic              q_any;
    logic [SLOT_W-1:0] q_idx;
    logic [SLOT_W-1:0] r_slot;
    logic              r_take;
    logic              alloc_dup;

    // Lowest free slot and lowest queued slot.
    always_comb begin
        free_any = 1'b0;
        free_idx = '0;
        q_any    = 1'b0;
        q_idx    = '0;
        for (int s = SLOTS - 1; s >= 0; s--) begin
            if (st_q[s] == SLOT_FREE) begin
                free_any = 1'b1;
                free_idx = SLOT_W'(s);
            end
            if (st_q[s] == SLOT_QUEUED) begin
                q_any = 1'b1;
                q_idx = SLOT_W'(s);
            end
        end
    end

    // Pending-line queries from the two lookup ports, plus a duplicate probe.
    always_comb begin
        qa_pend   = 1'b0;
        qb_pend   = 1'b0;
        alloc_dup = 1'b0;
        any_busy  = 1'b0;
        for (int s = 0; s < SLOTS; s++) begin
            if (st_q[s] != SLOT_FREE) begin
                any_busy = 1'b1;
                if (line_q[s] == qa_line)    qa_pend   = 1'b1;
                if (line_q[s] == qb_line)    qb_pend   = 1'b1;
                if (line_q[s] == alloc_line) alloc_dup = 1'b1;
            end
        end
    end

    // Response decode: the low ID bits select a slot, the high bits must be zero.
    always_comb begin
        r_slot    = r_id[SLOT_W-1:0];
        r_take    = r_valid && ((r_id >> SLOT_W) == '0) && (st_q[r_slot] == SLOT_WAIT);
        fill_en   = r_take;
        fill_line = line_q[r_slot];
    end

    // Slot state machine and the held read-address channel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SLOTS; s++) st_q[s] <= SLOT_FREE;
            ar_busy_q <= 1'b0;
            ar_slot_q <= '0;
        end else begin
            if (alloc_en)              st_q[free_idx]  <= SLOT_QUEUED;
            if (ar_busy_q && ar_ready) st_q[ar_slot_q] <= SLOT_WAIT;
            if (r_take)                st_q[r_slot]    <= SLOT_FREE;
            if (ar_busy_q) begin
                if (ar_ready) ar_busy_q <= 1'b0;
            end else if (q_any) begin
                ar_busy_q <= 1'b1;
                ar_slot_q <= q_idx;
            end
        end
    end

    // Line address captured when a slot is reserved.
    always_ff @(posedge clk) begin
        if (alloc_en) begin
            line_q[free_idx] <= alloc_line;
        end
    end

    assign ar_valid = ar_busy_q;
    assign ar_id    = ID_W'(ar_slot_q);
    assign ar_addr  = {line_q[ar_slot_q], {OFF_W{1'b0}}};

    // R6
    ar_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ar_valid && !ar_ready |=> ar_valid && $stable(ar_id) && $stable(ar_addr));
    // R9
    alloc_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_en |-> !alloc_dup && free_any);
    // R7
    fill_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
        r_take |=> st_q[$past(r_slot)] == SLOT_FREE);
endmodule

// File: rtl/fetch_line_cache.sv
// Direct-mapped read-only instruction cache returning a full line per
// fetch, refilled by single-beat AXI reads with next-line prefetch.
// Assumes LINES and SLOTS are powers of two (SLOTS >= 2, LINES >= 2),
// LINE_W is a power-of-two multiple of 32, and ID_W >= log2(SLOTS).
module fetch_line_cache
    import flc_pkg::*;
#(
    parameter int LINES  = 16,
    parameter int LINE_W = 128,
    parameter int SLOTS  = 4,
    parameter int ID_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_valid,
    output logic              flush_ready,
    input  logic              fetch_valid,
    output logic              fetch_ready,
    input  logic [31:0]       fetch_addr,
    output logic [LINE_W-1:0] fetch_rdata,
    output logic              ar_valid,
    input  logic              ar_ready,
    output logic [ID_W-1:0]   ar_id,
    output logic [31:0]       ar_addr,
    input  logic              r_valid,
    output logic              r_ready,
    input  logic [ID_W-1:0]   r_id,
    input  logic [1:0]        r_resp,
    input  logic [LINE_W-1:0] r_data
);
    localparam int LINE_BYTES = LINE_W / 8;
    localparam int OFF_W      = $clog2(LINE_BYTES);
    localparam int IDX_W      = $clog2(LINES);
    localparam int LA_W       = ADDR_W - OFF_W;
    localparam int TAG_W      = LA_W - IDX_W;

    logic [LA_W-1:0] f_line;
    logic [LA_W-1:0] n_line;
    logic            hit_a;
    logic            hit_b;
    logic            pend_a;
    logic            pend_b;
    logic            free_any;
    logic            any_busy;
    logic            need_dem;
    logic            need_pre;
    logic            alloc_en;
    logic [LA_W-1:0] alloc_line;
    logic            fill_en;
    logic [LA_W-1:0] fill_line;
    logic            flush_take;
    logic [OFF_W+1:0] unused_bits;

    assign unused_bits = {r_resp, fetch_addr[OFF_W-1:0]};

    // Split the fetch address into line, next line, set and tag.
    always_comb begin
        f_line = fetch_addr[ADDR_W-1:OFF_W];
        n_line = f_line + LA_W'(1);
    end

    // Refill decision: demand line first, next line otherwise; none during a flush request.
    always_comb begin
        need_dem   = fetch_valid && !hit_a && !pend_a;
        need_pre   = fetch_valid && !hit_a && !hit_b && !pend_b;
        alloc_en   = !flush_valid && free_any && (need_dem || need_pre);
        alloc_line = need_dem ? f_line : n_line;
    end

    // Handshake outputs.
    always_comb begin
        fetch_ready = hit_a;
        flush_ready = !any_busy;
        flush_take  = flush_valid && flush_ready;
        r_ready     = 1'b1;
    end

    flc_tag_store #(.LINES(LINES), .TAG_W(TAG_W)) u_tags (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (flush_take),
        .wr_en  (fill_en),
        .wr_idx (fill_line[IDX_W-1:0]),
        .wr_tag (fill_line[LA_W-1:IDX_W]),
        .a_idx  (f_line[IDX_W-1:0]),
        .a_tag  (f_line[LA_W-1:IDX_W]),
        .a_hit  (hit_a),
        .b_idx  (n_line[IDX_W-1:0]),
        .b_tag  (n_line[LA_W-1:IDX_W]),
        .b_hit  (hit_b)
    );

    flc_line_store #(.LINES(LINES), .LINE_W(LINE_W)) u_lines (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (fill_en),
        .wr_idx  (fill_line[IDX_W-1:0]),
        .wr_data (r_data),
        .rd_en   (fetch_valid && fetch_ready),
        .rd_idx  (f_line[IDX_W-1:0]),
        .rd_data (fetch_rdata)
    );

    flc_refill_tracker #(.SLOTS(SLOTS), .LA_W(LA_W), .OFF_W(OFF_W), .ID_W(ID_W)) u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .alloc_en   (alloc_en),
        .alloc_line (alloc_line),
        .free_any   (free_any),
        .any_busy   (any_busy),
        .qa_line    (f_line),
        .qa_pend    (pend_a),
        .qb_line    (n_line),
        .qb_pend    (pend_b),
        .ar_valid   (ar_valid),
        .ar_ready   (ar_ready),
        .ar_id      (ar_id),
        .ar_addr    (ar_addr),
        .r_valid    (r_valid),
        .r_id       (r_id),
        .fill_en    (fill_en),
        .fill_line  (fill_line)
    );

    // R1
    reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !ar_valid && flush_ready && !fetch_ready);
    // R10
    flush_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_take |=> !ar_valid && flush_ready);
    // R11
    flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_take |=> !fetch_ready);
endmodule

// File: tb/sim_fetch_line_cache.sv
`timescale 1ns/1ps
module sim_fetch_line_cache;
    localparam int LINES  = 8;
    localparam int LINE_W = 128;
    localparam int SLOTS  = 2;
    localparam int ID_W   = 3;
    localparam int LB     = LINE_W / 8;
    localparam int NW     = LINE_W / 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic              flush_valid = 1'b0;
    logic              flush_ready;
    logic              fetch_valid = 1'b0;
    logic              fetch_ready;
    logic [31:0]       fetch_addr = '0;
    logic [LINE_W-1:0] fetch_rdata;
    logic              ar_valid;
    logic              ar_ready;
    logic [ID_W-1:0]   ar_id;
    logic [31:0]       ar_addr;
    logic              r_valid;
    logic              r_ready;
    logic [ID_W-1:0]   r_id;
    logic [1:0]        r_resp;
    logic [LINE_W-1:0] r_data;

    fetch_line_cache #(.LINES(LINES), .LINE_W(LINE_W), .SLOTS(SLOTS), .ID_W(ID_W)) u0 (
        .clk(clk), .rst_n(rst_n),
        .flush_valid(flush_valid), .flush_ready(flush_ready),
        .fetch_valid(fetch_valid), .fetch_ready(fetch_ready),
        .fetch_addr(fetch_addr), .fetch_rdata(fetch_rdata),
        .ar_valid(ar_valid), .ar_ready(ar_ready), .ar_id(ar_id), .ar_addr(ar_addr),
        .r_valid(r_valid), .r_ready(r_ready), .r_id(r_id), .r_resp(r_resp), .r_data(r_data)
    );

    int errs = 0;
    int checks = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req,
                       input logic [LINE_W-1:0] act, input logic [LINE_W-1:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return (a * 32'h9E37_79B1) ^ 32'h1357_9BDF;
    endfunction

    function automatic logic [LINE_W-1:0] line_of(input logic [31:0] a);
        logic [LINE_W-1:0] v;
        logic [31:0] base;
        base = a & ~32'(LB - 1);
        for (int i = 0; i < NW; i++) v[32*i +: 32] = mem_word(base + 32'(4 * i));
        return v;
    endfunction

    // ---------------- AXI read slave model ----------------
    logic [ID_W-1:0] oid  [SLOTS];
    logic [31:0]     oadr [SLOTS];
    int  n = 0;
    bit  r_en = 1;
    bit  pick_last = 0;
    int  ar_count = 0;
    int  sk;
    bit  dup;
    logic pv = 0, pr = 0;
    logic [ID_W-1:0] pid = '0;
    logic [31:0] padr = '0;

    initial begin
        ar_ready = 1'b0; r_valid = 1'b0; r_id = '0; r_resp = '0; r_data = '0;
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                ar_ready = 1'b0; r_valid = 1'b0; n = 0; pv = 1'b0;
            end else begin
                // R10: flush may only be offered with nothing outstanding
                chk(!(flush_ready && n != 0), "R10 flush_ready while read outstanding", LINE_W'(n), 0);
                // R6: held read address
                if (pv && !pr)
                    chk(ar_valid && ar_id == pid && ar_addr == padr, "R6 read address not held",
                        {ar_valid, ar_id, ar_addr}, {1'b1, pid, padr});
                // R12: always ready for data
                chk(r_ready === 1'b1, "R12 r_ready low", LINE_W'(r_ready), 1);
                // Data beat, chosen from outstanding reads (any order)
                if (n > 0 && r_en && (pick_last || ($urandom % 2 == 0))) begin
                    sk = pick_last ? n - 1 : int'($urandom % n);
                    r_valid = 1'b1;
                    r_id    = oid[sk];
                    r_resp  = 2'($urandom % 4);
                    r_data  = line_of(oadr[sk]);
                    for (int j = sk; j < n - 1; j++) begin
                        oid[j]  = oid[j+1];
                        oadr[j] = oadr[j+1];
                    end
                    n--;
                end else begin
                    r_valid = 1'b0;
                    r_id    = '0;
                    r_data  = '0;
                end
                // Read address acceptance
                ar_ready = ($urandom % 2 == 0);
                if (ar_valid && ar_ready) begin
                    ar_count++;
                    chk(ar_addr % LB == 0, "R4 read address not line aligned", ar_addr, ar_addr & ~32'(LB - 1));
                    dup = 0;
                    for (int j = 0; j < n; j++) if (oid[j] == ar_id) dup = 1;
                    chk(int'(ar_id) < SLOTS && !dup, "R7 read ID out of range or in use", ar_id, 0);
                    dup = 0;
                    for (int j = 0; j < n; j++) if (oadr[j] == ar_addr) dup = 1;
                    chk(!dup && n < SLOTS, "R9 duplicate or excess outstanding read", LINE_W'(n), SLOTS);
                    if (n < SLOTS) begin
                        oid[n]  = ar_id;
                        oadr[n] = ar_addr;
                        n++;
                    end
                end
                pv = ar_valid; pr = ar_ready; pid = ar_id; padr = ar_addr;
            end
        end
    end

    // ---------------- fetch and flush drivers ----------------
    bit got_first;
    int waited;
    int c0;

    task automatic fetch(input logic [31:0] a);
        @(negedge clk);
        fetch_valid = 1'b1;
        fetch_addr  = a;
        #1;
        got_first = fetch_ready;
        waited = 0;
        while (!fetch_ready && waited <= 100) begin
            @(negedge clk); #1;
            waited++;
        end
        chk(waited <= 100, "R5 fetch not accepted within 100 cycles", LINE_W'(waited), 100);
        @(negedge clk);
        fetch_valid = 1'b0;
        chk(fetch_rdata == line_of(a), "R2 fetch line data", fetch_rdata, line_of(a));
    endtask

    task automatic do_flush();
        int w;
        @(negedge clk);
        flush_valid = 1'b1;
        #1;
        w = 0;
        while (!flush_ready && w < 200) begin
            @(negedge clk); #1;
            w++;
        end
        chk(w < 200, "R10 flush never accepted", LINE_W'(w), 0);
        @(negedge clk);
        flush_valid = 1'b0;
        chk(n == 0, "R10 flush accepted with reads outstanding", LINE_W'(n), 0);
    endtask

    task automatic wait_idle();
        int w;
        w = 0;
        do begin
            @(negedge clk); #1;
            w++;
        end while (!(flush_ready && n == 0) && w < 300);
        repeat (2) @(negedge clk);
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "WATCHDOG run did not end", 0, 1);
        report();
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        // R1: idle after reset
        chk(!ar_valid && flush_ready && !fetch_ready, "R1 reset state",
            {ar_valid, flush_ready, fetch_ready}, 3'b010);

        // R1 / R2: first fetch misses and still returns the right line
        fetch(32'h0000_0104);
        chk(!got_first, "R1 first fetch should miss", LINE_W'(got_first), 0);
        wait_idle();

        // R3: same line hits at once, no read
        c0 = ar_count;
        fetch(32'h0000_010C);
        chk(got_first, "R3 cached line not ready at once", LINE_W'(got_first), 1);
        chk(ar_count == c0, "R3 read issued on a hit", LINE_W'(ar_count), LINE_W'(c0));

        // R8: next line was brought in by the miss
        fetch(32'h0000_0110);
        chk(got_first, "R8 next line not prefetched", LINE_W'(got_first), 1);
        chk(ar_count == c0, "R8 read issued for prefetched line", LINE_W'(ar_count), LINE_W'(c0));

        // R7 / R9: hold data, then return the prefetch before the demand line
        wait_idle();
        r_en = 0;
        c0 = ar_count;
        fork
            fetch(32'h0000_2004);
            begin
                for (int w = 0; w < 60 && n < 2; w++) @(negedge clk);
                repeat (10) @(negedge clk);
                chk(n == 2, "R9 outstanding reads while data held", LINE_W'(n), 2);
                chk(ar_count == c0 + 2, "R8 demand plus next-line reads", LINE_W'(ar_count), LINE_W'(c0 + 2));
                pick_last = 1;
                r_en = 1;
            end
        join
        chk(!got_first, "R7 held fetch should have missed", LINE_W'(got_first), 0);
        wait_idle();
        pick_last = 0;
        c0 = ar_count;
        fetch(32'h0000_2018);
        chk(got_first, "R7 out-of-order beat filled wrong line", LINE_W'(got_first), 1);
        chk(ar_count == c0, "R7 refetch after out-of-order fill", LINE_W'(ar_count), LINE_W'(c0));

        // R11: flush invalidates a cached line
        fetch(32'h0000_2000);
        chk(got_first, "R11 line should be cached before flush", LINE_W'(got_first), 1);
        do_flush();
        c0 = ar_count;
        fetch(32'h0000_2000);
        chk(!got_first, "R11 line still valid after flush", LINE_W'(got_first), 0);
        chk(ar_count > c0, "R11 no read after flush", LINE_W'(ar_count), LINE_W'(c0 + 1));

        // R10: flush held off while reads are outstanding
        wait_idle();
        r_en = 0;
        fork
            fetch(32'h0000_3040);
            begin
                for (int w = 0; w < 60 && n < 1; w++) @(negedge clk);
                flush_valid = 1'b1;
                for (int w = 0; w < 8; w++) begin
                    @(negedge clk); #1;
                    chk(!flush_ready, "R10 flush accepted with data pending", LINE_W'(flush_ready), 0);
                end
                r_en = 1;
                for (int w = 0; w < 200 && !flush_ready; w++) begin
                    @(negedge clk); #1;
                end
                @(negedge clk);
                flush_valid = 1'b0;
                chk(n == 0, "R10 reads outstanding at flush", LINE_W'(n), 0);
            end
        join
        wait_idle();

        // Random phase: conflicts, wrap-around prefetch, random flushes and response codes
        for (int it = 0; it < 300; it++) begin
            logic [31:0] a;
            a = 32'h0000_4000 + 32'(($urandom % 24) * LB) + 32'($urandom % LB);
            if ($urandom % 8 == 0) a = 32'hFFFF_FFC0 + 32'($urandom % 64);
            fetch(a);
            if ($urandom % 20 == 0) do_flush();
        end
        wait_idle();
        report();
    end
endmodule